// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a low-power, four-bank SDRAM from reset to a usable state. It holds the command bus idle through the long power-up wait. It then closes all banks and runs two refresh cycles. Next it writes the standard mode register and after that the low-power extended mode register. It keeps the idle command on the bus for a counted number of cycles after every step. When the last wait has expired it raises a ready flag. A normal access controller can then take over the bus.

Each wait is given in nanoseconds together with the clock period in picoseconds. At elaboration the block turns each wait into a cycle count, rounding up. The two mode register values are parameters. The clock enable stays high at all times. Every command, bank and address output comes straight from a register, so all of them are stable at the rising edge on which the device samples them.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, the command pins {cs_n_o, ras_n_o, cas_n_o, we_n_o} carry NOP (4'b0111), ba_o and addr_o are zero and ready_o is low.
- R2: Counting rising edges after rst_ni is released, the first non-NOP command appears on the pins at edge PWRUP_CYC+2. Before that edge only NOP appears.
- R3: The non-NOP commands form exactly this list, in this order: PRECHARGE ALL, AUTO REFRESH, AUTO REFRESH, LOAD MODE REGISTER, LOAD MODE REGISTER. No other command code is ever driven.
- R4: PRECHARGE ALL is encoded as 4'b0010, with addr_o bit 10 set and every other addr_o bit clear.
- R5: AUTO REFRESH is encoded as 4'b0001. The first one comes RP_CYC+2 edges after PRECHARGE ALL. Every command is followed by at least one NOP cycle.
- R6: The second AUTO REFRESH comes RFC_CYC+2 edges after the first. The first mode register load comes RFC_CYC+2 edges after the second refresh.
- R7: LOAD MODE REGISTER is encoded as 4'b0000. The first load drives ba_o=2'b00 and addr_o=MODE_VAL.
- R8: The second load comes MRD_CYC+2 edges after the first and drives ba_o=2'b10 and addr_o=EXT_MODE_VAL. No load ever drives ba_o bit 0 high.
- R9: ready_o rises MRD_CYC+2 edges after the second load and then stays high. From then on only NOP is driven.
- R10: cke_o is high at all times, including during reset.
- R11: Asserting rst_ni at any point in the sequence returns the outputs to the R1 state. After release, the whole sequence restarts with the R2 timing.
- R12: Each cycle count equals ceil(ns*1000 / CLK_PERIOD_PS) for its wait, covering PWRUP, RP, RFC and MRD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the device samples the outputs on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_o | output | 1 | Clock enable, held high |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address bus; carries the mode values during loads |
| ready_o | output | 1 | High once initialization has completed |

## Verification
Every output is one register stage after the step state, and every step state is one timer-expiry cycle after its wait. The exact edge numbers are therefore:
- PWRUP_CYC+2 for the first command.
- Wait count plus 2 between consecutive commands.
- MRD_CYC+2 from the second load to ready.

The bench counts rising edges from reset release and samples on the falling edge, so a value registered at edge n is read with stamp n. Each command's stamp is compared for equality with the sum computed from the R12 formula, so an early or late command shows up as an off-by-one. The mid-sequence reset is checked one half cycle after assertion, and then the full timing is checked again from the new release.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_PRE,
    ST_W_RP,
    ST_REF1,
    ST_W_RFC1,
    ST_REF2,
    ST_W_RFC2,
    ST_MRS,
    ST_W_MRD1,
    ST_EMRS,
    ST_W_MRD2,
    ST_DONE
  } step_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per_ps);
    return (ns * 1000 + per_ps - 1) / per_ps;
  endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/init_cmd_drv.sv
module init_cmd_drv
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ready_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= CMD_NOP;
      ba_o    <= '0;
      addr_o  <= '0;
      ready_o <= 1'b0;
    end else begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= cmd_i;
      ba_o    <= ba_i;
      addr_o  <= addr_i;
      ready_o <= ready_i;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 13,
  parameter int unsigned       CLK_PERIOD_PS = 4000,
  parameter int unsigned       PWRUP_NS      = 100000,
  parameter int unsigned       RP_NS         = 18,
  parameter int unsigned       RFC_NS        = 72,
  parameter int unsigned       MRD_NS        = 10,
  parameter int unsigned       ALL_BANK_BIT  = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL      = ADDR_W'('h032),
  parameter logic [ADDR_W-1:0] EXT_MODE_VAL  = ADDR_W'('h000)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o
);

  localparam int unsigned PWRUP_CYC = ns_to_cyc(PWRUP_NS, CLK_PERIOD_PS);
  localparam int unsigned RP_CYC    = ns_to_cyc(RP_NS, CLK_PERIOD_PS);
  localparam int unsigned RFC_CYC   = ns_to_cyc(RFC_NS, CLK_PERIOD_PS);
  localparam int unsigned MRD_CYC   = ns_to_cyc(MRD_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_A     = (PWRUP_CYC > RFC_CYC) ? PWRUP_CYC : RFC_CYC;
  localparam int unsigned MAX_B     = (RP_CYC > MRD_CYC) ? RP_CYC : MRD_CYC;
  localparam int unsigned MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  step_e             st_q, st_d;
  cmd_e              cmd;
  logic [1:0]        ba;
  logic [ADDR_W-1:0] addr;
  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic              expired;

  assign cke_o = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_PWRUP;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d   = st_q;
    cmd    = CMD_NOP;
    ba     = '0;
    addr   = '0;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st_q)
      ST_PWRUP:  if (expired) st_d = ST_PRE;
      ST_PRE: begin
        cmd                = CMD_PRE;
        addr[ALL_BANK_BIT] = 1'b1;
        ld                 = 1'b1;
        ld_val             = CNT_W'(RP_CYC);
        st_d               = ST_W_RP;
      end
      ST_W_RP:   if (expired) st_d = ST_REF1;
      ST_REF1: begin
        cmd    = CMD_REF;
        ld     = 1'b1;
        ld_val = CNT_W'(RFC_CYC);
        st_d   = ST_W_RFC1;
      end
      ST_W_RFC1: if (expired) st_d = ST_REF2;
      ST_REF2: begin
        cmd    = CMD_REF;
        ld     = 1'b1;
        ld_val = CNT_W'(RFC_CYC);
        st_d   = ST_W_RFC2;
      end
      ST_W_RFC2: if (expired) st_d = ST_MRS;
      ST_MRS: begin
        cmd    = CMD_LMR;
        ba     = 2'b00;
        addr   = MODE_VAL;
        ld     = 1'b1;
        ld_val = CNT_W'(MRD_CYC);
        st_d   = ST_W_MRD1;
      end
      ST_W_MRD1: if (expired) st_d = ST_EMRS;
      ST_EMRS: begin
        cmd    = CMD_LMR;
        ba     = 2'b10;
        addr   = EXT_MODE_VAL;
        ld     = 1'b1;
        ld_val = CNT_W'(MRD_CYC);
        st_d   = ST_W_MRD2;
      end
      ST_W_MRD2: if (expired) st_d = ST_DONE;
      ST_DONE:   st_d = ST_DONE;
      default:   st_d = ST_PWRUP;
    endcase
  end

  init_wait_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (PWRUP_CYC)
  ) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .expired_o  (expired)
  );

  init_cmd_drv #(
    .ADDR_W (ADDR_W)
  ) i_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .ba_i    (ba),
    .addr_i  (addr),
    .ready_i (st_q == ST_DONE),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o),
    .ready_o (ready_o)
  );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned ALL_BANK_BIT = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ready_o
);

  logic [3:0] cmd;
  logic       seen_q;
  logic [3:0] since_q;

  assign cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  // NOP cycles since the last command, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      since_q <= '0;
    end else if (cmd != 4'b0111) begin
      seen_q  <= 1'b1;
      since_q <= '0;
    end else if (since_q != 4'hf) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_cmd_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd inside {4'b0111, 4'b0010, 4'b0001, 4'b0000});

  p_pre_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0010) |-> (addr_o == ADDR_W'(1) << ALL_BANK_BIT) && (ba_o == 2'b00));

  p_cmd_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != 4'b0111 && seen_q) |-> (since_q >= 4'd1));

  p_lmr_bank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0000) |-> (ba_o[0] == 1'b0));

  p_ready_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  p_ready_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cmd == 4'b0111));

endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W       (ADDR_W),
  .ALL_BANK_BIT (ALL_BANK_BIT)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_n_o  (cs_n_o),
  .ras_n_o (ras_n_o),
  .cas_n_o (cas_n_o),
  .we_n_o  (we_n_o),
  .ba_o    (ba_o),
  .addr_o  (addr_o),
  .ready_o (ready_o)
);

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps
module test_sdram_init_seq;

  localparam int unsigned ADDR_W   = 13;
  localparam int unsigned PER_PS   = 4000;
  localparam int unsigned PWRUP_NS = 2002;
  localparam int unsigned RP_NS    = 18;
  localparam int unsigned RFC_NS   = 72;
  localparam int unsigned MRD_NS   = 10;
  localparam logic [ADDR_W-1:0] MODE = 13'h0032;
  localparam logic [ADDR_W-1:0] EXT  = 13'h0060;

  // R12: ceil(ns*1000/period)
  localparam int E_PWRUP = (PWRUP_NS * 1000 + PER_PS - 1) / PER_PS;
  localparam int E_RP    = (RP_NS * 1000 + PER_PS - 1) / PER_PS;
  localparam int E_RFC   = (RFC_NS * 1000 + PER_PS - 1) / PER_PS;
  localparam int E_MRD   = (MRD_NS * 1000 + PER_PS - 1) / PER_PS;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ready_o;
  logic [1:0] ba_o;
  logic [ADDR_W-1:0] addr_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  int cyc;
  int n_cmd = 0;
  int ready_cyc = -1;
  logic [3:0] rec_cmd [16];
  logic [1:0] rec_ba [16];
  logic [ADDR_W-1:0] rec_addr [16];
  int rec_cyc [16];

  always #2 clk = ~clk;

  sdram_init_seq #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_PS (PER_PS),
    .PWRUP_NS      (PWRUP_NS),
    .RP_NS         (RP_NS),
    .RFC_NS        (RFC_NS),
    .MRD_NS        (MRD_NS),
    .MODE_VAL      (MODE),
    .EXT_MODE_VAL  (EXT)
  ) i_sdram_init_seq (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .cke_o   (cke_o),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o),
    .ready_o (ready_o)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  // stamp = rising edges since reset release
  always @(negedge clk) begin
    if (rst_ni) begin
      if ({cs_n_o, ras_n_o, cas_n_o, we_n_o} != 4'b0111) begin
        if (n_cmd < 16) begin
          rec_cmd[n_cmd]  = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
          rec_ba[n_cmd]   = ba_o;
          rec_addr[n_cmd] = addr_o;
          rec_cyc[n_cmd]  = cyc;
        end
        n_cmd = n_cmd + 1;
      end
      if (ready_o && ready_cyc < 0) ready_cyc = cyc;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic release_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    n_cmd     = 0;
    ready_cyc = -1;
    rst_ni    = 1'b1;
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "cmd in reset", {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'b0111);
    chk("R1", "ba in reset", ba_o, 0);
    chk("R1", "addr in reset", addr_o, 0);
    chk("R1", "ready in reset", ready_o, 0);
    chk("R10", "cke in reset", cke_o, 1);
  endtask

  task automatic t_full_seq(input string tag);
    int lim = 0;
    int p;
    while (ready_cyc < 0 && lim < 5000) begin
      @(negedge clk);
      lim++;
    end
    chk("R3", {tag, " command count"}, n_cmd, 5);
    if (n_cmd == 5) begin
      p = E_PWRUP + 2;
      chk("R2", {tag, " first command stamp"}, rec_cyc[0], p);
      chk("R4", {tag, " precharge code"}, rec_cmd[0], 4'b0010);
      chk("R4", {tag, " precharge addr"}, rec_addr[0], 13'h0400);
      chk("R5", {tag, " refresh1 code"}, rec_cmd[1], 4'b0001);
      chk("R5", {tag, " refresh1 stamp"}, rec_cyc[1], p + E_RP + 2);
      chk("R6", {tag, " refresh2 code"}, rec_cmd[2], 4'b0001);
      chk("R6", {tag, " refresh2 stamp"}, rec_cyc[2], rec_cyc[1] + E_RFC + 2);
      chk("R7", {tag, " load1 code"}, rec_cmd[3], 4'b0000);
      chk("R6", {tag, " load1 stamp"}, rec_cyc[3], rec_cyc[2] + E_RFC + 2);
      chk("R7", {tag, " load1 bank"}, rec_ba[3], 2'b00);
      chk("R7", {tag, " load1 value"}, rec_addr[3], MODE);
      chk("R8", {tag, " load2 code"}, rec_cmd[4], 4'b0000);
      chk("R8", {tag, " load2 stamp"}, rec_cyc[4], rec_cyc[3] + E_MRD + 2);
      chk("R8", {tag, " load2 bank"}, rec_ba[4], 2'b10);
      chk("R8", {tag, " load2 value"}, rec_addr[4], EXT);
      chk("R9", {tag, " ready stamp"}, ready_cyc, rec_cyc[4] + E_MRD + 2);
    end
  endtask

  task automatic t_after_ready();
    repeat (100) @(negedge clk);
    chk("R9", "no command after ready", n_cmd, 5);
    chk("R9", "ready held", ready_o, 1);
    chk("R10", "cke after ready", cke_o, 1);
  endtask

  task automatic t_mid_reset();
    int lim = 0;
    release_reset();
    while (n_cmd < 2 && lim < 5000) begin
      @(negedge clk);
      lim++;
    end
    chk("R11", "reached refresh before reset", n_cmd, 2);
    @(posedge clk);
    #1 rst_ni = 1'b0;
    @(negedge clk);
    chk("R11", "cmd after mid reset", {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'b0111);
    chk("R11", "addr after mid reset", addr_o, 0);
    chk("R11", "ready after mid reset", ready_o, 0);
    release_reset();
    t_full_seq("R11 restart");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    t_reset_state();
    release_reset();
    t_full_seq("R2 first run");
    t_after_ready();
    t_mid_reset();
    summary();
  end

endmodule